// File: doc/BRIEF.md
# SPI Slave Receiver with Low-Power Wakeup

This block is the receive side of a serial peripheral port working as a slave. An external master sends bytes on a serial clock, a data line and an active-low select. The block brings these lines into the system clock domain and assembles each byte. It holds the first unread byte in a data register. Three status flags report a finished byte, a byte lost to overrun, and a select conflict while the port is set to the master role. All three flags share one interrupt request line.

The block also takes part in the chip's low-power states. While the wait input is high it runs normally, and any enabled interrupt raises the wake output. While the halt input is high the register port is frozen, but the block still receives bytes. It raises wake only for a finished byte whose interrupt is enabled, and only if the slave select was low when halt began. When halt ends in slave mode, the block enters a recovery state. The next complete byte is taken as a dummy transfer that returns the port to normal operation.

Software drives the configuration through a write strobe and one-cycle clear strobes for each flag.

Top module: `spi_halt_slave`

## Requirements
- R1: After reset, rx_data_o is 0 and eot_o, ovr_o, modf_o, irq_o, wake_o and recover_o are all 0.
- R2: In slave mode, with the effective select low, the block samples mosi_i on each rising sck_i edge, most significant bit first. After 8 rising edges it loads the byte into rx_data_o and sets eot_o. When the select goes high, any partly received bits are discarded.
- R3: If a byte completes while eot_o is already set, ovr_o is set and rx_data_o keeps the earlier byte.
- R4: A one-cycle pulse on clr_eot_i, clr_ovr_i or clr_modf_i clears that flag. If a set event for the same flag arrives in the same cycle, the set wins.
- R5: irq_o is high when irq_mask_i is 0 and at least one flag is set whose enable is also set. The enables are cfg_wdata_i bit 0 for eot, bit 1 for ovr and bit 2 for modf.
- R6: When cfg bit 3 is 1, the effective select is cfg bit 4 (low means selected) and the ss_n_i pin is ignored. When cfg bit 3 is 0, the effective select is the pin.
- R7: When cfg bit 5 (master role) is 1, a falling edge of the effective select sets modf_o, and no bytes are received.
- R8: While wait_i is high and halt_i is low, wake_o follows irq_o.
- R9: While halt_i is high, wake_o is 1 only when eot_o and the eot enable are both set and the effective select was low when halt_i rose. irq_mask_i has no effect on this.
- R10: A mode fault never raises wake_o during halt.
- R11: While halt_i is high, clear strobes and configuration writes have no effect, but reception continues.
- R12: When halt_i falls with the master role off, recover_o goes to 1. The next complete byte is then discarded: rx_data_o and the flags stay unchanged, and recover_o clears. Selecting the master role clears recover_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Slave select pin, active low |
| wait_i | input | 1 | Chip is in wait state |
| halt_i | input | 1 | Chip is in halt state |
| irq_mask_i | input | 1 | Global interrupt mask |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration: [0] eot enable, [1] ovr enable, [2] modf enable, [3] software select, [4] software select level, [5] master role |
| clr_eot_i | input | 1 | Clear strobe for end-of-transfer flag |
| clr_ovr_i | input | 1 | Clear strobe for overrun flag |
| clr_modf_i | input | 1 | Clear strobe for mode-fault flag |
| rx_data_o | output | 8 | Received data register |
| eot_o | output | 1 | End-of-transfer flag |
| ovr_o | output | 1 | Overrun flag |
| modf_o | output | 1 | Mode-fault flag |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wakeup request to the power controller |
| recover_o | output | 1 | Halt-recovery state |

## Verification
The hardest situation to reach is the halt path. Its outcome depends on the select level captured when halt began, and it also depends on the register port being frozen during halt. The stimulus enters halt twice, once with the select pin high and once with it low, and sends a byte in each case. This shows that the captured level decides whether wake is raised. The bench then tries clears and configuration writes during halt. After halt exits, it sends a dummy byte to show it is discarded. A third halt is entered in the master role, and a select fall during that halt is used to show that a mode fault cannot wake the chip.

// File: rtl/spi_halt_pkg.sv
// Shared configuration layout for the SPI slave with halt wakeup.
// Assumes the configuration word is written as one flat vector by software.
package spi_halt_pkg;
    localparam int CFG_W = 6;

    // Configuration fields, msb first; bit 0 is the eot enable.
    typedef struct packed {
        logic master_sel;   // bit 5: master role selected
        logic sw_ss_level;  // bit 4: software select level (0 = selected)
        logic sw_ss_sel;    // bit 3: use software select instead of pin
        logic modf_ie;      // bit 2: mode-fault interrupt enable
        logic ovr_ie;       // bit 1: overrun interrupt enable
        logic eot_ie;       // bit 0: end-of-transfer interrupt enable
    } cfg_t;
endpackage

// File: rtl/spi_sync_bank.sv
// Multi-stage synchroniser bank for asynchronous serial lines.
// Assumes each line is independent; reset value chosen per bit.
module spi_sync_bank #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Shift the raw line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end

        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_rx_shift.sv
// Mode-0 receive shifter: samples data on each rising serial clock while
// active, msb first, and pulses done_o with the assembled word.
// Assumes inputs are already synchronised to clk.
module spi_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s_i,
    input  logic              mosi_s_i,
    input  logic              active_i,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic              sck_prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              rise;

    assign rise = sck_s_i & ~sck_prev_q;

    // Remember last serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s_i;
    end

    // Shift in bits and count them; emit a word after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            done_o  <= 1'b0;
            word_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (!active_i) begin
                cnt_q <= '0;
            end else if (rise) begin
                shreg_q <= {shreg_q[DATA_W-2:0], mosi_s_i};
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    done_o <= 1'b1;
                    word_o <= {shreg_q[DATA_W-2:0], mosi_s_i};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_evt_ctrl.sv
// Flags, data register, configuration, interrupt and low-power control.
// Assumes halt_i and wait_i are synchronous; while halted the register
// port is frozen but received words still update flags and data.
module spi_evt_ctrl
    import spi_halt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              ss_eff_i,
    input  logic              wait_i,
    input  logic              halt_i,
    input  logic              irq_mask_i,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              clr_eot_i,
    input  logic              clr_ovr_i,
    input  logic              clr_modf_i,
    output cfg_t              cfg_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              eot_o,
    output logic              ovr_o,
    output logic              modf_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              recover_o
);
    logic ss_prev_q;
    logic halt_q;
    logic ss_low_at_halt_q;
    logic accept, rx_evt, discard, modf_evt, halt_wake;

    assign accept   = word_done_i & ~cfg_o.master_sel;
    assign rx_evt   = accept & ~recover_o;
    assign discard  = accept & recover_o;
    assign modf_evt = cfg_o.master_sel & ss_prev_q & ~ss_eff_i;

    // Configuration register; writes ignored while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_o <= '0;
        else if (cfg_we_i && !halt_i) cfg_o <= cfg_t'(cfg_wdata_i);
    end

    // Track select level and halt state; capture select at halt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_prev_q        <= 1'b1;
            halt_q           <= 1'b0;
            ss_low_at_halt_q <= 1'b0;
        end else begin
            ss_prev_q <= ss_eff_i;
            halt_q    <= halt_i;
            if (halt_i && !halt_q) ss_low_at_halt_q <= ~ss_eff_i;
        end
    end

    // Data register loads only when no unread word is held.
    always_ff @(posedge clk) begin
        if (!rst_n)               rx_data_o <= '0;
        else if (rx_evt && !eot_o) rx_data_o <= word_i;
    end

    // Status flags: set events win over clear strobes; clears frozen in halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_o  <= 1'b0;
            ovr_o  <= 1'b0;
            modf_o <= 1'b0;
        end else begin
            if (rx_evt)                      eot_o <= 1'b1;
            else if (clr_eot_i && !halt_i)   eot_o <= 1'b0;
            if (rx_evt && eot_o)             ovr_o <= 1'b1;
            else if (clr_ovr_i && !halt_i)   ovr_o <= 1'b0;
            if (modf_evt)                    modf_o <= 1'b1;
            else if (clr_modf_i && !halt_i)  modf_o <= 1'b0;
        end
    end

    // Halt-recovery state: entered on halt exit in slave role.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   recover_o <= 1'b0;
        else if (cfg_o.master_sel)                    recover_o <= 1'b0;
        else if (halt_q && !halt_i)                   recover_o <= 1'b1;
        else if (discard)                             recover_o <= 1'b0;
    end

    // Shared interrupt request and wakeup request.
    always_comb begin
        irq_o = ~irq_mask_i & ((eot_o & cfg_o.eot_ie) |
                               (ovr_o & cfg_o.ovr_ie) |
                               (modf_o & cfg_o.modf_ie));
        halt_wake = halt_q & ss_low_at_halt_q & eot_o & cfg_o.eot_ie;
        wake_o = halt_i ? halt_wake : (wait_i & irq_o);
    end
endmodule

// File: rtl/spi_halt_slave.sv
// Top: SPI slave receiver with interrupt and halt/wait wakeup control.
// Assumes serial lines are asynchronous to clk and much slower than it.
module spi_halt_slave
    import spi_halt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    input  logic              wait_i,
    input  logic              halt_i,
    input  logic              irq_mask_i,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              clr_eot_i,
    input  logic              clr_ovr_i,
    input  logic              clr_modf_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              eot_o,
    output logic              ovr_o,
    output logic              modf_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              recover_o
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw, synced;
    logic             ss_eff, shift_active, word_done;
    logic [DATA_W-1:0] word;
    cfg_t             cfg;

    assign raw = {sck_i, mosi_i, ss_n_i};

    spi_sync_bank #(
        .WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
    );

    // Effective select: software bit or synchronised pin.
    always_comb begin
        ss_eff       = cfg.sw_ss_sel ? cfg.sw_ss_level : synced[0];
        shift_active = ~ss_eff & ~cfg.master_sel;
    end

    spi_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck_s_i(synced[2]), .mosi_s_i(synced[1]),
        .active_i(shift_active),
        .done_o(word_done), .word_o(word)
    );

    spi_evt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .word_done_i(word_done), .word_i(word),
        .ss_eff_i(ss_eff), .wait_i(wait_i), .halt_i(halt_i),
        .irq_mask_i(irq_mask_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .clr_eot_i(clr_eot_i), .clr_ovr_i(clr_ovr_i), .clr_modf_i(clr_modf_i),
        .cfg_o(cfg),
        .rx_data_o(rx_data_o), .eot_o(eot_o), .ovr_o(ovr_o), .modf_o(modf_o),
        .irq_o(irq_o), .wake_o(wake_o), .recover_o(recover_o)
    );
endmodule

// File: rtl/spi_halt_slave_chk.sv
// Property checker for spi_halt_slave, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module spi_halt_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wait_i,
    input logic              halt_i,
    input logic              irq_mask_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              eot_o,
    input logic              ovr_o,
    input logic              irq_o,
    input logic              wake_o
);
    // R5: a masked chip never sees the request.
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_i |-> !irq_o);

    // R3: overrun only appears on top of an unread word.
    assert_ovr_needs_eot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(eot_o));

    // R3: unread data is never overwritten.
    assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eot_o) |-> $stable(rx_data_o));

    // R8: in wait, any request wakes the chip.
    assert_wait_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && wait_i && irq_o) |-> wake_o);

    // R9: halt wakeup requires a finished word.
    assert_halt_wake_eot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && wake_o) |-> eot_o);

    // R10: without a finished word (mode fault alone) halt is not left.
    assert_no_modf_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !eot_o) |-> !wake_o);

    // R11: the eot flag cannot be cleared while halted.
    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt_i) && $past(eot_o)) |-> eot_o);
endmodule

bind spi_halt_slave spi_halt_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_i), .halt_i(halt_i),
    .irq_mask_i(irq_mask_i), .rx_data_o(rx_data_o), .eot_o(eot_o),
    .ovr_o(ovr_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/spi_halt_slave_bench.sv
// Scoreboard bench: driver pushes expected items, negedge monitor compares.
module spi_halt_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic wait_in = 1'b0, halt_in = 1'b0, mask = 1'b0;
    logic cfg_we = 1'b0;
    logic [5:0] cfg_wd = '0;
    logic clr_eot = 1'b0, clr_ovr = 1'b0, clr_modf = 1'b0;
    logic [7:0] rx_data;
    logic eot, ovr, modf, irq, wake, recover;

    int total = 0, bad = 0;
    bit done_flag = 1'b0;

    typedef struct { string req; int sel; logic [7:0] exp; } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    spi_halt_slave u_spi_halt_slave (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
        .wait_i(wait_in), .halt_i(halt_in), .irq_mask_i(mask),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
        .clr_eot_i(clr_eot), .clr_ovr_i(clr_ovr), .clr_modf_i(clr_modf),
        .rx_data_o(rx_data), .eot_o(eot), .ovr_o(ovr), .modf_o(modf),
        .irq_o(irq), .wake_o(wake), .recover_o(recover)
    );

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0: return rx_data;
            1: return {7'd0, eot};
            2: return {7'd0, ovr};
            3: return {7'd0, modf};
            4: return {7'd0, irq};
            5: return {7'd0, wake};
            default: return {7'd0, recover};
        endcase
    endfunction

    // Monitor: drain the scoreboard at each falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = pick(it.sel);
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: output %0d actual=%0h expected=%0h",
                         it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_out(string req, int sel, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spi_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            settle(4);
            sck = 1'b1;
            settle(4);
            sck = 1'b0;
        end
        settle(8);
    endtask

    task automatic write_cfg(logic [5:0] v);
        cfg_wd = v; cfg_we = 1'b1;
        settle(1);
        cfg_we = 1'b0;
        settle(4);
    endtask

    task automatic clear(logic e, logic o, logic m);
        clr_eot = e; clr_ovr = o; clr_modf = m;
        settle(1);
        clr_eot = 1'b0; clr_ovr = 1'b0; clr_modf = 1'b0;
        settle(2);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        if (!done_flag) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(2);
        // R1 reset state
        for (int s = 0; s < 7; s++) expect_out("R1", s, 8'h00);
        settle(1);

        // R2 receive, R5 irq
        write_cfg(6'b000001);
        ss_n = 1'b0; settle(4);
        spi_byte(8'hA5);
        expect_out("R2", 0, 8'hA5); expect_out("R2", 1, 1);
        expect_out("R5", 4, 1); expect_out("R3", 2, 0);
        settle(1);
        mask = 1'b1; settle(1);
        expect_out("R5", 4, 0);
        settle(1); mask = 1'b0;

        // R3 overrun keeps first byte
        spi_byte(8'h3C);
        expect_out("R3", 2, 1); expect_out("R3", 0, 8'hA5);
        settle(1);
        write_cfg(6'b000010);
        clear(1, 0, 0);
        expect_out("R5", 4, 1); expect_out("R4", 1, 0);
        settle(1);
        clear(0, 1, 0);
        expect_out("R4", 2, 0); expect_out("R5", 4, 0);
        settle(1);

        // R2 partial byte discarded by select going high
        write_cfg(6'b000001);
        mosi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            settle(4); sck = 1'b1; settle(4); sck = 1'b0;
        end
        settle(4);
        ss_n = 1'b1; settle(6); ss_n = 1'b0; settle(6);
        spi_byte(8'h5A);
        expect_out("R2", 0, 8'h5A);
        settle(1);
        clear(1, 0, 0);

        // R6 software select overrides pin
        write_cfg(6'b011001);
        spi_byte(8'hF0);
        expect_out("R6", 1, 0); expect_out("R6", 0, 8'h5A);
        settle(1);
        ss_n = 1'b1;
        write_cfg(6'b001001);
        spi_byte(8'h81);
        expect_out("R6", 0, 8'h81); expect_out("R6", 1, 1);
        settle(1);
        clear(1, 0, 0);

        // R7 mode fault through software select in master role
        write_cfg(6'b111100);
        write_cfg(6'b101100);
        expect_out("R7", 3, 1); expect_out("R5", 4, 1);
        settle(1);
        spi_byte(8'h99);
        expect_out("R7", 1, 0);
        settle(1);
        clear(0, 0, 1);
        expect_out("R4", 3, 0);
        settle(1);
        ss_n = 1'b0; settle(4);
        write_cfg(6'b000001);

        // R8 wait wakeup
        wait_in = 1'b1; settle(1);
        expect_out("R8", 5, 0);
        settle(1);
        spi_byte(8'h42);
        expect_out("R8", 5, 1);
        settle(1);
        clear(1, 0, 0);
        wait_in = 1'b0;

        // R9 halt entered with select high: no wakeup
        ss_n = 1'b1; settle(6);
        halt_in = 1'b1; settle(2);
        ss_n = 1'b0; settle(6);
        spi_byte(8'h77);
        expect_out("R9", 1, 1); expect_out("R9", 5, 0); expect_out("R11", 0, 8'h77);
        settle(1);
        clear(1, 0, 0);
        expect_out("R11", 1, 1);
        settle(1);
        halt_in = 1'b0; settle(2);
        expect_out("R12", 6, 1);
        settle(1);
        clear(1, 0, 0);
        spi_byte(8'h11);
        expect_out("R12", 0, 8'h77); expect_out("R12", 1, 0); expect_out("R12", 6, 0);
        settle(1);
        spi_byte(8'h22);
        expect_out("R12", 0, 8'h22);
        settle(1);
        clear(1, 0, 0);

        // R9 halt entered with select low, mask set: wakeup
        mask = 1'b1;
        halt_in = 1'b1; settle(2);
        spi_byte(8'hC3);
        expect_out("R9", 5, 1); expect_out("R9", 0, 8'hC3); expect_out("R5", 4, 0);
        settle(1);
        write_cfg(6'b000000);
        expect_out("R11", 5, 1);
        settle(1);
        halt_in = 1'b0; settle(2);
        expect_out("R12", 6, 1);
        settle(1);
        write_cfg(6'b100000);
        expect_out("R12", 6, 0);
        settle(1);
        mask = 1'b0;
        clear(1, 0, 0);

        // R10 mode fault during halt does not wake
        write_cfg(6'b100101);
        ss_n = 1'b1; settle(6); ss_n = 1'b0; settle(6);
        expect_out("R7", 3, 1);
        settle(1);
        clear(0, 0, 1);
        halt_in = 1'b1; settle(2);
        ss_n = 1'b1; settle(6); ss_n = 1'b0; settle(6);
        expect_out("R10", 3, 1); expect_out("R10", 5, 0); expect_out("R10", 4, 1);
        settle(1);
        halt_in = 1'b0; settle(2);
        expect_out("R12", 6, 0);
        settle(2);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule